// File: doc/BRIEF.md
# CBC Chaining Unit

This block applies cipher-block chaining to a stream of 128-bit blocks on top of an external single-block cipher. Plaintext or ciphertext blocks arrive on a valid/ready input stream. The unit sends each one to the cipher through a request/response port and mixes it with a running chain value. The finished blocks leave on a valid/ready output stream. The cipher keeps no state of its own: the unit holds the 128-bit key and passes it with every request.

Software loads a 128-bit IV register and a 128-bit key register, then starts a command. A command carries a direction, an enable, a continuation flag and a block count. With continuation clear, the chain value is reloaded from the IV register. With continuation set, the chain value is the last ciphertext block of the previous command. This lets one long message be split into several back-to-back commands. With enable clear, blocks are copied from input to output, the cipher is never called, and the chain value is left alone.

Top module: `cbc_chainer`

## Requirements
- R1: After reset, busy_o, in_ready_o, out_valid_o and cph_req_valid_o are 0 and the chain value is zero. A continued encrypt issued first uses an all-zero chain value.
- R2: When encrypting (dir_i = 0), each output block is E(P xor chain). That output becomes the new chain value. A command with cont_i = 0 first loads the chain value from the IV register.
- R3: When decrypting (dir_i = 1), each output block is D(C) xor chain, and the input block C becomes the new chain value.
- R4: A command with cont_i = 1 starts from the last ciphertext block of the previous command. For an encrypt this is the last output block; for a decrypt it is the last input block.
- R5: With en_i = 0, every output block equals its input block and no cipher request is issued.
- R6: A pass-through command leaves the chain value unchanged for any later continued command.
- R7: Only one block is in flight. in_ready_o stays low from the cycle a block is accepted until its output block has been taken, and the output stays valid until it is taken.
- R8: len_i holds the block count minus one, so the all-ones value means 2^LEN_W blocks. busy_o stays high from the start until the last output block is taken. start_i is ignored while busy_o is high.
- R9: Each cipher request carries the current key register value and the command's direction bit (0 encrypt, 1 decrypt). Its data and direction stay stable while cph_req_ready_i is low. A key write takes effect for later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iv_we_i | input | 1 | Write strobe for the IV register |
| iv_i | input | BLK_W | IV value to write |
| key_we_i | input | 1 | Write strobe for the key register |
| key_i | input | BLK_W | Key value to write |
| start_i | input | 1 | Starts a command when idle |
| len_i | input | LEN_W | Block count minus one |
| dir_i | input | 1 | 0 encrypt, 1 decrypt |
| en_i | input | 1 | 1 use the cipher, 0 pass-through copy |
| cont_i | input | 1 | 1 keep the chain value, 0 reload from IV |
| busy_o | output | 1 | Command in progress |
| in_valid_i | input | 1 | Input block valid |
| in_ready_o | output | 1 | Input block accepted when high with valid |
| in_data_i | input | BLK_W | Input block |
| out_valid_o | output | 1 | Output block valid |
| out_ready_i | input | 1 | Output block taken when high with valid |
| out_data_o | output | BLK_W | Output block |
| cph_req_valid_o | output | 1 | Cipher request valid |
| cph_req_ready_i | input | 1 | Cipher accepts the request |
| cph_req_dir_o | output | 1 | Cipher direction, 0 encrypt, 1 decrypt |
| cph_req_key_o | output | BLK_W | Key for the cipher |
| cph_req_data_o | output | BLK_W | Block to transform |
| cph_rsp_valid_i | input | 1 | Cipher result valid, one cycle, at least one cycle after request acceptance |
| cph_rsp_data_i | input | BLK_W | Cipher result |

## Verification
The bench builds the unit with BLK_W = 128 and LEN_W = 3. Commands therefore run from one to eight blocks, and the all-ones length, which is the longest command, is exercised directly along with single-block commands. The cipher is a keyed rotate-and-mask permutation that answers after a random delay with random request back-pressure. This brings request holding, output holding, and chain carry-over across encrypt, decrypt and pass-through commands within reach in a short run.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAKE,
    ST_REQ,
    ST_WAIT,
    ST_GIVE
  } cbc_state_e;

  localparam logic DIR_ENC = 1'b0;
  localparam logic DIR_DEC = 1'b1;
endpackage

// File: rtl/cbc_regs.sv
module cbc_regs #(
  parameter int BLK_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iv_we_i,
  input  logic [BLK_W-1:0] iv_i,
  input  logic             key_we_i,
  input  logic [BLK_W-1:0] key_i,
  output logic [BLK_W-1:0] iv_o,
  output logic [BLK_W-1:0] key_o
);
  localparam int NREG = 2;

  logic             we   [NREG];
  logic [BLK_W-1:0] wdat [NREG];
  logic [BLK_W-1:0] val_q[NREG];

  assign we[0]   = iv_we_i;
  assign wdat[0] = iv_i;
  assign we[1]   = key_we_i;
  assign wdat[1] = key_i;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    val_q[g] <= '0;
      else if (we[g]) val_q[g] <= wdat[g];
    end
  end

  assign iv_o  = val_q[0];
  assign key_o = val_q[1];
endmodule

// File: rtl/cbc_seq.sv
module cbc_seq
  import cbc_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dir_i,
  input  logic             en_i,
  input  logic             cont_i,
  input  logic             in_valid_i,
  input  logic             out_ready_i,
  input  logic             req_ready_i,
  input  logic             rsp_valid_i,
  output logic             busy_o,
  output logic             dir_o,
  output logic             en_o,
  output logic             load_iv_o,
  output logic             take_o,
  output logic             rsp_take_o,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic             req_valid_o
);
  cbc_state_e       state_q, state_d;
  logic [LEN_W-1:0] left_q;
  logic             dir_q, en_q;
  logic             go;

  assign go          = (state_q == ST_IDLE) && start_i;
  assign load_iv_o   = go && !cont_i;
  assign in_ready_o  = (state_q == ST_TAKE);
  assign take_o      = in_ready_o && in_valid_i;
  assign req_valid_o = (state_q == ST_REQ);
  assign rsp_take_o  = (state_q == ST_WAIT) && rsp_valid_i;
  assign out_valid_o = (state_q == ST_GIVE);
  assign busy_o      = (state_q != ST_IDLE);
  assign dir_o       = dir_q;
  assign en_o        = en_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)     state_d = ST_TAKE;
      ST_TAKE: if (in_valid_i)  state_d = en_q ? ST_REQ : ST_GIVE;
      ST_REQ:  if (req_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i) state_d = ST_GIVE;
      ST_GIVE: if (out_ready_i) state_d = (left_q == '0) ? ST_IDLE : ST_TAKE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      dir_q   <= DIR_ENC;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (go) begin
        left_q <= len_i;
        dir_q  <= dir_i;
        en_q   <= en_i;
      end else if (out_valid_o && out_ready_i && left_q != '0) begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assert_one_flight_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !out_valid_o && !req_valid_o);
  assert_out_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o);
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !in_ready_o && !out_valid_o && !req_valid_o);
  assert_bypass_noreq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !en_q |-> !req_valid_o);
endmodule

// File: rtl/cbc_chain.sv
module cbc_chain
  import cbc_pkg::*;
#(
  parameter int BLK_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_iv_i,
  input  logic [BLK_W-1:0] iv_i,
  input  logic             take_i,
  input  logic             en_i,
  input  logic             dir_i,
  input  logic [BLK_W-1:0] in_data_i,
  input  logic             rsp_take_i,
  input  logic [BLK_W-1:0] rsp_data_i,
  output logic [BLK_W-1:0] hold_o,
  output logic [BLK_W-1:0] out_o
);
  logic [BLK_W-1:0] chain_q, hold_q, out_q;

  // hold_q: pre-whitened block on encrypt, saved ciphertext on decrypt
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      hold_q  <= '0;
      out_q   <= '0;
    end else begin
      if (load_iv_i) chain_q <= iv_i;
      if (take_i) begin
        if (!en_i)                hold_q <= hold_q;
        else if (dir_i == DIR_ENC) hold_q <= in_data_i ^ chain_q;
        else                       hold_q <= in_data_i;
        if (!en_i) out_q <= in_data_i;
      end
      if (rsp_take_i) begin
        if (dir_i == DIR_ENC) begin
          out_q   <= rsp_data_i;
          chain_q <= rsp_data_i;
        end else begin
          out_q   <= rsp_data_i ^ chain_q;
          chain_q <= hold_q;
        end
      end
    end
  end

  assign hold_o = hold_q;
  assign out_o  = out_q;

  assert_enc_chain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_take_i && dir_i == DIR_ENC |=> out_q == chain_q);
  assert_bypass_chain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !load_iv_i |=> $stable(chain_q));
endmodule

// File: rtl/cbc_chainer.sv
module cbc_chainer #(
  parameter int BLK_W = 128,
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iv_we_i,
  input  logic [BLK_W-1:0] iv_i,
  input  logic             key_we_i,
  input  logic [BLK_W-1:0] key_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dir_i,
  input  logic             en_i,
  input  logic             cont_i,
  output logic             busy_o,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [BLK_W-1:0] in_data_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [BLK_W-1:0] out_data_o,
  output logic             cph_req_valid_o,
  input  logic             cph_req_ready_i,
  output logic             cph_req_dir_o,
  output logic [BLK_W-1:0] cph_req_key_o,
  output logic [BLK_W-1:0] cph_req_data_o,
  input  logic             cph_rsp_valid_i,
  input  logic [BLK_W-1:0] cph_rsp_data_i
);
  logic [BLK_W-1:0] iv_q, key_q;
  logic             dir_q, en_q, load_iv, take, rsp_take;

  cbc_regs #(.BLK_W(BLK_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .iv_we_i  (iv_we_i),
    .iv_i     (iv_i),
    .key_we_i (key_we_i),
    .key_i    (key_i),
    .iv_o     (iv_q),
    .key_o    (key_q)
  );

  cbc_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .len_i       (len_i),
    .dir_i       (dir_i),
    .en_i        (en_i),
    .cont_i      (cont_i),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .req_ready_i (cph_req_ready_i),
    .rsp_valid_i (cph_rsp_valid_i),
    .busy_o      (busy_o),
    .dir_o       (dir_q),
    .en_o        (en_q),
    .load_iv_o   (load_iv),
    .take_o      (take),
    .rsp_take_o  (rsp_take),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .req_valid_o (cph_req_valid_o)
  );

  cbc_chain #(.BLK_W(BLK_W)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_iv_i  (load_iv),
    .iv_i       (iv_q),
    .take_i     (take),
    .en_i       (en_q),
    .dir_i      (dir_q),
    .in_data_i  (in_data_i),
    .rsp_take_i (rsp_take),
    .rsp_data_i (cph_rsp_data_i),
    .hold_o     (cph_req_data_o),
    .out_o      (out_data_o)
  );

  assign cph_req_dir_o = dir_q;
  assign cph_req_key_o = key_q;

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cph_req_valid_o && !cph_req_ready_i |=>
      cph_req_valid_o && $stable(cph_req_data_o) && $stable(cph_req_dir_o));
  assert_out_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(out_data_o));
endmodule

// File: tb/cbc_chainer_test.sv
`timescale 1ns/1ps
module cbc_chainer_test;
  localparam int BW = 128;
  localparam int LW = 3;
  localparam logic [BW-1:0] MASK = 128'h5a3c_96e1_0f87_d24b_3c69_a5f0_1e2d_b487;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic iv_we = 0, key_we = 0, start = 0, dir = 0, en = 0, cont = 0;
  logic [BW-1:0] iv_d = '0, key_d = '0, in_data = '0;
  logic [LW-1:0] len = '0;
  logic in_valid = 0, out_ready = 0, req_ready = 0, rsp_valid = 0;
  logic [BW-1:0] rsp_data = '0;
  logic busy, in_ready, out_valid, req_valid, req_dir;
  logic [BW-1:0] out_data, req_key, req_data;

  int n_run = 0, n_fail = 0, req_seen = 0;
  logic [BW-1:0] m_chain = '0, m_iv = '0, m_key = '0;
  logic m_dir = 0, m_en = 0;

  cbc_chainer #(.BLK_W(BW), .LEN_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .iv_we_i(iv_we), .iv_i(iv_d), .key_we_i(key_we), .key_i(key_d),
    .start_i(start), .len_i(len), .dir_i(dir), .en_i(en), .cont_i(cont),
    .busy_o(busy),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .cph_req_valid_o(req_valid), .cph_req_ready_i(req_ready),
    .cph_req_dir_o(req_dir), .cph_req_key_o(req_key), .cph_req_data_o(req_data),
    .cph_rsp_valid_i(rsp_valid), .cph_rsp_data_i(rsp_data)
  );

  function automatic logic [BW-1:0] ciph_e(input logic [BW-1:0] x, input logic [BW-1:0] k);
    logic [BW-1:0] t = x ^ k;
    return {t[BW-6:0], t[BW-1:BW-5]} ^ MASK;
  endfunction

  function automatic logic [BW-1:0] ciph_d(input logic [BW-1:0] y, input logic [BW-1:0] k);
    logic [BW-1:0] t = y ^ MASK;
    return {t[4:0], t[BW-1:5]} ^ k;
  endfunction

  function automatic logic [BW-1:0] r128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cipher stand-in: random back-pressure and latency
  initial begin
    logic pend = 0, vld_p = 0, rdy_p = 0, dir_p = 0;
    logic [BW-1:0] dat_p = '0, key_p = '0, res = '0;
    int dly = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (!rst_n) begin
        pend = 0; vld_p = 0; rdy_p = 0; req_ready = 0;
      end else begin
        if (rdy_p && vld_p) begin
          req_seen++;
          pend = 1;
          dly  = $urandom % 3;
          res  = dir_p ? ciph_d(dat_p, key_p) : ciph_e(dat_p, key_p);
        end else if (pend) begin
          if (dly == 0) begin
            rsp_valid = 1'b1;
            rsp_data  = res;
            pend      = 0;
          end else dly--;
        end
        vld_p = req_valid; dat_p = req_data; key_p = req_key; dir_p = req_dir;
        req_ready = ($urandom % 4) != 0;
        rdy_p = req_ready;
      end
    end
  end

  task automatic wr_key(input logic [BW-1:0] k);
    @(negedge clk); key_we = 1; key_d = k;
    @(negedge clk); key_we = 0;
    m_key = k;
  endtask

  task automatic wr_iv(input logic [BW-1:0] v);
    @(negedge clk); iv_we = 1; iv_d = v;
    @(negedge clk); iv_we = 0;
    m_iv = v;
  endtask

  task automatic do_start(input logic d, input logic e, input logic c, input int nblk);
    @(negedge clk);
    start = 1; dir = d; en = e; cont = c; len = LW'(nblk - 1);
    @(negedge clk);
    start = 0;
    m_dir = d; m_en = e;
    if (!c) m_chain = m_iv;
  endtask

  task automatic model(input logic [BW-1:0] x, output logic [BW-1:0] y);
    if (!m_en) y = x;
    else if (!m_dir) begin y = ciph_e(x ^ m_chain, m_key); m_chain = y; end
    else begin y = ciph_d(x, m_key) ^ m_chain; m_chain = x; end
  endtask

  task automatic xfer(input logic [BW-1:0] x, output logic [BW-1:0] got);
    int bad = 0;
    in_valid = 1; in_data = x;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    forever begin
      if (in_ready) bad++;
      out_ready = ($urandom % 4) != 0;
      if (out_valid && out_ready) begin
        got = out_data;
        @(negedge clk);
        out_ready = 0;
        break;
      end
      @(negedge clk);
    end
    chk("R7 in_ready while block in flight", BW'(bad), '0);
  endtask

  function automatic string mode_tag(input logic d, input logic e, input logic c);
    if (!e) return "R5 pass-through data";
    if (c)  return "R4 continued chain";
    return d ? "R3 decrypt" : "R2 encrypt";
  endfunction

  task automatic run_cmd(input logic d, input logic e, input logic c, input int nblk);
    logic [BW-1:0] x, got, exp;
    string tag = mode_tag(d, e, c);
    do_start(d, e, c, nblk);
    for (int i = 0; i < nblk; i++) begin
      x = r128();
      xfer(x, got);
      model(x, exp);
      chk(tag, got, exp);
    end
    @(negedge clk);
    chk("R8 busy after last block", BW'(busy), '0);
  endtask

  initial begin
    logic [BW-1:0] got, exp, x;
    int snap;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", BW'(busy), '0);
    chk("R1 in_ready at reset", BW'(in_ready), '0);
    chk("R1 out_valid at reset", BW'(out_valid), '0);
    chk("R1 req_valid at reset", BW'(req_valid), '0);
    rst_n = 1;
    wr_key(r128());
    // R1: continued encrypt right after reset uses zero chain
    do_start(1'b0, 1'b1, 1'b1, 1);
    x = r128(); xfer(x, got);
    chk("R1 zero chain after reset", got, ciph_e(x, m_key));
    m_chain = got;

    wr_iv(r128());
    run_cmd(1'b0, 1'b1, 1'b0, 3);
    run_cmd(1'b0, 1'b1, 1'b1, 2);
    wr_iv(r128());
    run_cmd(1'b1, 1'b1, 1'b0, 3);
    run_cmd(1'b1, 1'b1, 1'b1, 2);

    // R5/R6: pass-through issues no request and keeps the chain
    run_cmd(1'b0, 1'b1, 1'b0, 2);
    snap = req_seen;
    run_cmd(1'b1, 1'b0, 1'b1, 3);
    chk("R5 no cipher request in pass-through", BW'(req_seen - snap), '0);
    do_start(1'b0, 1'b1, 1'b1, 1);
    x = r128(); xfer(x, got); model(x, exp);
    chk("R6 chain kept across pass-through", got, exp);

    // R8: longest command
    run_cmd(1'b0, 1'b1, 1'b1, 1 << LW);
    run_cmd(1'b1, 1'b1, 1'b0, 1 << LW);

    // R8: start while busy is ignored
    do_start(1'b0, 1'b1, 1'b0, 2);
    x = r128(); xfer(x, got); model(x, exp);
    chk("R2 first block before stray start", got, exp);
    @(negedge clk); start = 1; en = 0; cont = 0; dir = 1; len = '0;
    @(negedge clk); start = 0;
    x = r128(); xfer(x, got); model(x, exp);
    chk("R8 stray start ignored", got, exp);
    @(negedge clk);
    chk("R8 busy after ignored start", BW'(busy), '0);

    // R9: new key applies to later requests
    wr_key(r128());
    run_cmd(1'b0, 1'b1, 1'b1, 2);
    chk("R9 request key equals key register", req_key, m_key);
    wr_key(r128());
    run_cmd(1'b1, 1'b1, 1'b1, 2);

    for (int k = 0; k < 30; k++) begin
      if ($urandom % 5 == 0) wr_key(r128());
      if ($urandom % 3 == 0) wr_iv(r128());
      run_cmd(1'($urandom), ($urandom % 4) != 0, 1'($urandom), 1 + ($urandom % (1 << LW)));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule